// File: doc/BRIEF.md
# Interconnect Target Error Log Bank

This block sits next to one target port of an on-chip interconnect and records the details of the first failing transaction that reaches it. When the error detector asserts a capture strobe, the block stores the error class, the initiator ID, the transaction opcode, the request qualifier bits and the target-side address offset. It then raises a registered pending flag. Later failures are dropped until software clears the log.

Software reads the stored record through a simple single-cycle register bus. Standard errors, raised by the interconnect itself, and custom errors, raised by the target, are shown through two separate groups of registers. Only the group that matches the stored class returns data. Every other location reads zero. Software clears the log by writing the main status register with its top bit set. The initiator ID is placed in an 8-bit address field, either in its upper six bits or in its lower six bits, as chosen by a parameter.

Top module: `errlog_bank`

## Requirements
- R1: After reset `log_valid` is 0 and every register location reads 0.
- R2: A capture strobe while the log is empty sets `log_valid` on the next clock edge. From then on, the main register at 0x48 reads bit 0 = 1 (pending) and bit 1 = the stored class (1 custom, 0 standard). All other bits of that register are 0.
- R3: A write to 0x48 with bit 31 set empties the log, and `log_valid` is 0 after that edge. Afterwards every location reads 0. A write to 0x48 with bit 31 clear, or a write to any other offset, changes nothing.
- R4: While the log holds a record, further capture strobes leave the record unchanged. A capture strobe in the same cycle as a clearing write is discarded.
- R5: For a standard record, the registers read as follows. 0x4C returns the 3-bit opcode in bits 2:0. The opcode values are 0 idle, 1 write, 2 read, 3 exclusive read, 4 read-link, 5 non-posted write, 6 conditional write and 7 broadcast write. 0x50 returns the 8-bit initiator address field. 0x58 returns the 4 qualifier bits in bits 3:0: bit 0 instruction fetch, bit 1 supervisor, bit 3 debug. 0x5C returns the target address offset.
- R6: For a custom record, the registers read as follows. 0x64 returns the qualifier bits in bits 3:0. 0x68 returns the initiator address field. 0x6C returns the opcode in bits 2:0.
- R7: Registers that belong to the other class read 0. Unmapped offsets, for example 0x00, 0x54 and 0x60, read 0.
- R8: With `ID_UPPER`=1 the 6-bit initiator ID appears in bits 7:2 of the initiator address field. With `ID_UPPER`=0 it appears in bits 5:0. The remaining bits of the field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | Capture strobe from the error detector |
| cap_custom | input | 1 | 1 = target-generated error, 0 = interconnect error |
| cap_id | input | 6 | Initiator ID of the failing request |
| cap_op | input | 3 | Transaction opcode |
| cap_qual | input | 4 | Request qualifier bits |
| cap_ofs | input | OFS_W | Target-side address offset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| log_valid | output | 1 | Registered pending-error flag |

## Verification
The bench targets four kinds of mistake:
- Overwriting the record. It sends a second strobe, with different values, while a record is held. A design without the hold would report the second error's opcode instead of the first one's.
- Clear priority and decoding. It drives a clear and a capture in the same cycle. It also writes the main register with bit 31 low, and writes bit 31 to a non-main offset. A wrong priority or a loose decode would either leave the log pending or empty it.
- Register groups. It reads both register groups after each class of capture. A design that shows data regardless of class would return nonzero values from the group that should read zero.
- Initiator ID placement. Two instances with opposite `ID_UPPER` settings receive the same traffic. A shift on the wrong side would give 0x2D where 0xB4 is expected, or the reverse.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int ID_W   = 6;
    localparam int IDF_W  = 8;
    localparam int OP_W   = 3;
    localparam int QUAL_W = 4;

    // Register byte offsets
    localparam logic [7:0] RA_MAIN   = 8'h48;
    localparam logic [7:0] RA_S_OP   = 8'h4C;
    localparam logic [7:0] RA_S_MST  = 8'h50;
    localparam logic [7:0] RA_S_QUAL = 8'h58;
    localparam logic [7:0] RA_S_SLV  = 8'h5C;
    localparam logic [7:0] RA_C_QUAL = 8'h64;
    localparam logic [7:0] RA_C_MST  = 8'h68;
    localparam logic [7:0] RA_C_OP   = 8'h6C;

    localparam int MAIN_PEND_BIT  = 0;
    localparam int MAIN_CLASS_BIT = 1;
    localparam int MAIN_CLR_BIT   = 31;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_READ    = 3'd2,
        OP_READEX  = 3'd3,
        OP_RDLINK  = 3'd4,
        OP_WRNP    = 3'd5,
        OP_WRCOND  = 3'd6,
        OP_WRBCAST = 3'd7
    } opcode_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MAIN,
        SEL_S_OP,
        SEL_S_MST,
        SEL_S_QUAL,
        SEL_S_SLV,
        SEL_C_QUAL,
        SEL_C_MST,
        SEL_C_OP
    } regsel_e;

    typedef struct packed {
        logic                pend;
        logic                custom;
        logic [ID_W-1:0]     id;
        opcode_e             op;
        logic [QUAL_W-1:0]   qual;
    } log_hdr_t;

endpackage

// File: rtl/errlog_adec.sv
module errlog_adec
    import errlog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output regsel_e           sel_o
);

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == ADDR_W'(RA_MAIN))        sel_o = SEL_MAIN;
        else if (addr_i == ADDR_W'(RA_S_OP))   sel_o = SEL_S_OP;
        else if (addr_i == ADDR_W'(RA_S_MST))  sel_o = SEL_S_MST;
        else if (addr_i == ADDR_W'(RA_S_QUAL)) sel_o = SEL_S_QUAL;
        else if (addr_i == ADDR_W'(RA_S_SLV))  sel_o = SEL_S_SLV;
        else if (addr_i == ADDR_W'(RA_C_QUAL)) sel_o = SEL_C_QUAL;
        else if (addr_i == ADDR_W'(RA_C_MST))  sel_o = SEL_C_MST;
        else if (addr_i == ADDR_W'(RA_C_OP))   sel_o = SEL_C_OP;
    end

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
#(
    parameter int OFS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid_i,
    input  logic              cap_custom_i,
    input  logic [ID_W-1:0]   cap_id_i,
    input  logic [OP_W-1:0]   cap_op_i,
    input  logic [QUAL_W-1:0] cap_qual_i,
    input  logic [OFS_W-1:0]  cap_ofs_i,
    input  logic              clr_i,
    output log_hdr_t          hdr_o,
    output logic [OFS_W-1:0]  ofs_o
);

    typedef struct packed {
        log_hdr_t         hdr;
        logic [OFS_W-1:0] ofs;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            // clearing write wins over any capture in the same cycle
            st_d = '0;
        end else if (cap_valid_i && !st_q.hdr.pend) begin
            st_d.hdr.pend   = 1'b1;
            st_d.hdr.custom = cap_custom_i;
            st_d.hdr.id     = cap_id_i;
            st_d.hdr.op     = opcode_e'(cap_op_i);
            st_d.hdr.qual   = cap_qual_i;
            // offset is only part of the standard record
            st_d.ofs        = cap_custom_i ? '0 : cap_ofs_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_o = st_q.hdr;
    assign ofs_o = st_q.ofs;

endmodule

// File: rtl/errlog_rdmux.sv
module errlog_rdmux
    import errlog_pkg::*;
#(
    parameter int OFS_W    = 32,
    parameter int DATA_W   = 32,
    parameter bit ID_UPPER = 1'b1
) (
    input  logic              rd_i,
    input  regsel_e           sel_i,
    input  log_hdr_t          hdr_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int PAD_W = IDF_W - ID_W;

    logic [IDF_W-1:0]  id_field;
    logic              std_live;
    logic              cus_live;
    logic [DATA_W-1:0] main_word;
    logic [DATA_W-1:0] val;

    generate
        if (ID_UPPER) begin : g_id_hi
            assign id_field = {hdr_i.id, {PAD_W{1'b0}}};
        end else begin : g_id_lo
            assign id_field = {{PAD_W{1'b0}}, hdr_i.id};
        end
    endgenerate

    assign std_live = hdr_i.pend && !hdr_i.custom;
    assign cus_live = hdr_i.pend &&  hdr_i.custom;

    always_comb begin
        main_word                 = '0;
        main_word[MAIN_PEND_BIT]  = hdr_i.pend;
        main_word[MAIN_CLASS_BIT] = hdr_i.custom;
    end

    always_comb begin
        val = '0;
        unique case (sel_i)
            SEL_MAIN:   val = main_word;
            SEL_S_OP:   if (std_live) val = DATA_W'(hdr_i.op);
            SEL_S_MST:  if (std_live) val = DATA_W'(id_field);
            SEL_S_QUAL: if (std_live) val = DATA_W'(hdr_i.qual);
            SEL_S_SLV:  if (std_live) val = DATA_W'(ofs_i);
            SEL_C_QUAL: if (cus_live) val = DATA_W'(hdr_i.qual);
            SEL_C_MST:  if (cus_live) val = DATA_W'(id_field);
            SEL_C_OP:   if (cus_live) val = DATA_W'(hdr_i.op);
            default:    val = '0;
        endcase
    end

    assign rdata_o = rd_i ? val : '0;

endmodule

// File: rtl/errlog_bank.sv
module errlog_bank
    import errlog_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int OFS_W    = 32,
    parameter bit ID_UPPER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic              cap_custom,
    input  logic [5:0]        cap_id,
    input  logic [2:0]        cap_op,
    input  logic [3:0]        cap_qual,
    input  logic [OFS_W-1:0]  cap_ofs,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              log_valid
);

    regsel_e          sel;
    log_hdr_t         hdr;
    logic [OFS_W-1:0] ofs;
    logic             clr;
    logic             rd;
    logic             cls_now;
    logic             unused_wdata;

    errlog_adec #(.ADDR_W(ADDR_W)) u_adec (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    assign clr = bus_en && bus_we && (sel == SEL_MAIN) && bus_wdata[MAIN_CLR_BIT];
    assign rd  = bus_en && !bus_we;
    assign unused_wdata = ^bus_wdata[DATA_W-2:0];

    errlog_capture #(.OFS_W(OFS_W)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_valid_i  (cap_valid),
        .cap_custom_i (cap_custom),
        .cap_id_i     (cap_id),
        .cap_op_i     (cap_op),
        .cap_qual_i   (cap_qual),
        .cap_ofs_i    (cap_ofs),
        .clr_i        (clr),
        .hdr_o        (hdr),
        .ofs_o        (ofs)
    );

    errlog_rdmux #(
        .OFS_W    (OFS_W),
        .DATA_W   (DATA_W),
        .ID_UPPER (ID_UPPER)
    ) u_rd (
        .rd_i    (rd),
        .sel_i   (sel),
        .hdr_i   (hdr),
        .ofs_i   (ofs),
        .rdata_o (bus_rdata)
    );

    assign log_valid = hdr.pend;
    assign cls_now   = hdr.custom;

endmodule

// File: rtl/errlog_checks.sv
module errlog_checks #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_valid,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              log_valid,
    input logic              log_custom
);

    logic clr_wr;
    logic rd_other;
    logic rd_unmapped;

    assign clr_wr = bus_en && bus_we && (bus_addr == ADDR_W'(8'h48)) && bus_wdata[31];

    assign rd_other = bus_en && !bus_we && log_valid && (
        (log_custom && (bus_addr == ADDR_W'(8'h4C) || bus_addr == ADDR_W'(8'h50) ||
                        bus_addr == ADDR_W'(8'h58) || bus_addr == ADDR_W'(8'h5C))) ||
        (!log_custom && (bus_addr == ADDR_W'(8'h64) || bus_addr == ADDR_W'(8'h68) ||
                         bus_addr == ADDR_W'(8'h6C))));

    assign rd_unmapped = bus_en && !bus_we &&
        (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h54) || bus_addr == ADDR_W'(8'h60));

    // R2: strobe into an empty log raises the flag one edge later
    p_capture_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !log_valid && !clr_wr) |=> log_valid);

    // R3: a clearing write drops the flag one edge later
    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !log_valid);

    // R4: a held record stays held until cleared
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !clr_wr) |=> (log_valid && $stable(log_custom)));

    // R1: with no strobe an empty log stays empty
    p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_valid && !cap_valid) |=> !log_valid);

    // R7: other-class and unmapped locations read zero
    p_other_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_other || rd_unmapped) |-> (bus_rdata == '0));

    // R1: an empty log reads zero everywhere
    p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !log_valid) |-> (bus_rdata == '0));

endmodule

bind errlog_bank errlog_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_valid  (cap_valid),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .log_valid  (log_valid),
    .log_custom (cls_now)
);

// File: tb/sim_errlog_bank.sv
module sim_errlog_bank;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic        cap_custom = 1'b0;
    logic [5:0]  cap_id = '0;
    logic [2:0]  cap_op = '0;
    logic [3:0]  cap_qual = '0;
    logic [31:0] cap_ofs = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        lv0, lv1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    errlog_bank #(.ID_UPPER(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_custom(cap_custom),
        .cap_id(cap_id), .cap_op(cap_op), .cap_qual(cap_qual), .cap_ofs(cap_ofs),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata0), .log_valid(lv0)
    );

    errlog_bank #(.ID_UPPER(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_custom(cap_custom),
        .cap_id(cap_id), .cap_op(cap_op), .cap_qual(cap_qual), .cap_ofs(cap_ofs),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1), .log_valid(lv1)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d0 = rdata0; d1 = rdata1;
        bus_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        #1;
    endtask

    task automatic cap(input logic cu, input logic [5:0] id, input logic [2:0] op,
                       input logic [3:0] q, input logic [31:0] o);
        @(negedge clk);
        cap_valid = 1'b1; cap_custom = cu; cap_id = id; cap_op = op; cap_qual = q; cap_ofs = o;
        @(negedge clk);
        cap_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        chk("R1", "log_valid after reset", 32'(lv0), 32'h0);
        rd(8'h48, a, b); chk("R1", "main after reset", a, 32'h0);
        rd(8'h50, a, b); chk("R1", "initiator after reset", a, 32'h0);
    endtask

    task automatic t_standard();
        logic [31:0] a, b;
        @(negedge clk);
        cap_valid = 1'b1; cap_custom = 1'b0; cap_id = 6'h2D; cap_op = 3'd5;
        cap_qual = 4'hB; cap_ofs = 32'h0001_2344;
        #1;
        chk("R2", "log_valid before edge", 32'(lv0), 32'h0);
        @(negedge clk);
        cap_valid = 1'b0;
        #1;
        chk("R2", "log_valid after edge", 32'(lv0), 32'h1);
        rd(8'h48, a, b); chk("R2", "main standard", a, 32'h1);
        rd(8'h4C, a, b); chk("R5", "std opcode", a, 32'h5);
        rd(8'h50, a, b);
        chk("R5", "std initiator upper", a, 32'hB4);
        chk("R8", "initiator low placement", b, 32'h2D);
        rd(8'h58, a, b); chk("R5", "std qualifier", a, 32'hB);
        rd(8'h5C, a, b); chk("R5", "std offset", a, 32'h0001_2344);
        rd(8'h64, a, b); chk("R7", "custom qual in std", a, 32'h0);
        rd(8'h68, a, b); chk("R7", "custom mst in std", a, 32'h0);
        rd(8'h6C, a, b); chk("R7", "custom op in std", a, 32'h0);
    endtask

    task automatic t_first_kept();
        logic [31:0] a, b;
        cap(1'b1, 6'h11, 3'd2, 4'h1, 32'hFFFF);
        rd(8'h48, a, b); chk("R4", "main kept", a, 32'h1);
        rd(8'h4C, a, b); chk("R4", "opcode kept", a, 32'h5);
    endtask

    task automatic t_unmapped();
        logic [31:0] a, b;
        rd(8'h00, a, b); chk("R7", "unmapped 0x00", a, 32'h0);
        rd(8'h54, a, b); chk("R7", "unmapped 0x54", a, 32'h0);
        rd(8'h60, a, b); chk("R7", "unmapped 0x60", a, 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] a, b;
        wr(8'h48, 32'h7FFF_FFFF);
        chk("R3", "write without bit31", 32'(lv0), 32'h1);
        wr(8'h4C, 32'h8000_0000);
        chk("R3", "bit31 at other offset", 32'(lv0), 32'h1);
        wr(8'h48, 32'h8000_0000);
        chk("R3", "clear drops valid", 32'(lv0), 32'h0);
        rd(8'h5C, a, b); chk("R3", "offset after clear", a, 32'h0);
        rd(8'h48, a, b); chk("R3", "main after clear", a, 32'h0);
    endtask

    task automatic t_custom();
        logic [31:0] a, b;
        cap(1'b1, 6'h07, 3'd3, 4'h6, 32'h0ABC);
        chk("R2", "log_valid custom", 32'(lv0), 32'h1);
        rd(8'h48, a, b); chk("R2", "main custom", a, 32'h3);
        rd(8'h64, a, b); chk("R6", "custom qualifier", a, 32'h6);
        rd(8'h68, a, b);
        chk("R6", "custom initiator upper", a, 32'h1C);
        chk("R8", "custom initiator low", b, 32'h07);
        rd(8'h6C, a, b); chk("R6", "custom opcode", a, 32'h3);
        rd(8'h4C, a, b); chk("R7", "std op in custom", a, 32'h0);
        rd(8'h5C, a, b); chk("R7", "std offset in custom", a, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] a, b;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h8000_0000;
        cap_valid = 1'b1; cap_custom = 1'b0; cap_id = 6'h3F; cap_op = 3'd1;
        cap_qual = 4'h0; cap_ofs = 32'h10;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; cap_valid = 1'b0;
        #1;
        chk("R4", "capture with clear dropped", 32'(lv0), 32'h0);
        rd(8'h48, a, b); chk("R4", "main after clear+capture", a, 32'h0);
        cap(1'b0, 6'h01, 3'd7, 4'h8, 32'h40);
        rd(8'h48, a, b); chk("R2", "recapture main", a, 32'h1);
        rd(8'h4C, a, b); chk("R5", "broadcast opcode", a, 32'h7);
        rd(8'h58, a, b); chk("R5", "debug qualifier", a, 32'h8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_standard();
        t_first_kept();
        t_unmapped();
        t_clear();
        t_custom();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule